// File: doc/BRIEF.md
# Flash Write Pulse Sequencer

This block produces one timed flash programming pulse. It is driven by a controller that owns the data transfer, the verify pass and the retry count. A one-cycle `start` request together with a two-bit width select launches a fixed sequence of three control strobes.

First the watchdog enable rises. One cycle later the setup strobe rises. After a settle time the program strobe is raised for the selected pulse width. The program strobe then drops, followed by the setup strobe, and finally the watchdog enable. Each of these edges has its own settle delay, and every delay is a parameter given in clock cycles.

The controller normally picks the short width for the early attempts on a page, the long width for later ones, and the additional width for reinforcement pulses. This block does not count attempts. It applies whatever width was selected when the request was accepted.

Top module: `flash_pulse_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy`, `wdg_en`, `setup_stb`, `prog_stb` and `done` are all low.
- R2: A `start` sampled high while idle raises `wdg_en` in the next cycle. The following run lengths then hold in order:
  - `wdg_en` alone: 1 cycle.
  - `wdg_en` with `setup_stb`: Y_CYC cycles.
  - all three strobes: the selected width.
  - `wdg_en` with `setup_stb`: ALPHA_CYC cycles.
  - `wdg_en` alone: BETA_CYC cycles.
- R3: `prog_stb` is high only while `setup_stb` is high and has already been high for at least Y_CYC cycles.
- R4: `setup_stb` is high only while `wdg_en` is high. `wdg_en` rises before `setup_stb` and falls after it.
- R5: The width select is encoded as follows:
  - `2'b00` selects Z1_CYC (short).
  - `2'b01` selects Z2_CYC (long).
  - `2'b10` and `2'b11` select Z3_CYC (additional).
- R6: `busy` is high from the cycle after a start is accepted up to and including the `done` cycle. A `start` that arrives while `busy` is high is ignored and does not restart or lengthen the sequence.
- R7: `done` is a single-cycle pulse. It is high in exactly the cycle in which `wdg_en` first returns low.
- R8: The width select is captured when a start is accepted. Changing it later has no effect on the pulse in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one programming pulse |
| width_sel | input | 2 | Pulse width select (00 short, 01 long, 1x additional) |
| busy | output | 1 | Sequence in progress |
| wdg_en | output | 1 | Watchdog enable, covers the whole pulse |
| setup_stb | output | 1 | Pre-program setup strobe |
| prog_stb | output | 1 | Program strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the program strobe stays nested inside a settled setup strobe;
- the setup strobe stays inside the watchdog window;
- `done` is single-cycle and coincides with the watchdog falling;
- a busy sequencer never re-enters its arming phase;
- the captured width never moves during the program phase.

Other properties only the bench scenarios can show:
- the exact length of every phase for each of the four width-select codes;
- that a width change plus a second start in mid-pulse leaves the measured pulse untouched;
- that back-to-back requests each yield one complete sequence.

// File: rtl/fps_pkg.sv
package fps_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_ARM     = 3'd1,
      PH_SETTLE  = 3'd2,
      PH_PULSE   = 3'd3,
      PH_HOLD    = 3'd4,
      PH_RELEASE = 3'd5,
      PH_FINISH  = 3'd6
   } fps_phase_e;

   typedef enum logic [1:0] {
      WSEL_SHORT = 2'b00,
      WSEL_LONG  = 2'b01,
      WSEL_EXTRA = 2'b10,
      WSEL_ALT   = 2'b11
   } fps_wsel_e;

   typedef struct packed {
      logic busy;
      logic wdg;
      logic setup;
      logic prog;
      logic done;
   } fps_strobes_t;

   function automatic int unsigned fps_max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic fps_strobes_t fps_decode(input fps_phase_e ph);
      fps_strobes_t s;
      s.busy  = (ph != PH_IDLE);
      s.wdg   = (ph == PH_ARM) || (ph == PH_SETTLE) || (ph == PH_PULSE) ||
                (ph == PH_HOLD) || (ph == PH_RELEASE);
      s.setup = (ph == PH_SETTLE) || (ph == PH_PULSE) || (ph == PH_HOLD);
      s.prog  = (ph == PH_PULSE);
      s.done  = (ph == PH_FINISH);
      return s;
   endfunction

endpackage

// File: rtl/fps_phase_timer.sv
module fps_phase_timer #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/fps_width_sel.sv
module fps_width_sel
   import fps_pkg::*;
#(
   parameter int unsigned CW     = 4,
   parameter int unsigned Z1_CYC = 4,
   parameter int unsigned Z2_CYC = 8,
   parameter int unsigned Z3_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [1:0]    sel,
   output logic [CW-1:0] width_m1
);
   localparam logic [CW-1:0] Z1_M1 = CW'(Z1_CYC - 1);
   localparam logic [CW-1:0] Z2_M1 = CW'(Z2_CYC - 1);
   localparam logic [CW-1:0] Z3_M1 = CW'(Z3_CYC - 1);

   fps_wsel_e sel_q;

   // R8: selection captured only on an accepted start
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= WSEL_SHORT;
      end else if (capture) begin
         sel_q <= fps_wsel_e'(sel);
      end
   end

   // R5: width code mapping
   always_comb begin
      unique case (sel_q)
         WSEL_SHORT: width_m1 = Z1_M1;
         WSEL_LONG:  width_m1 = Z2_M1;
         default:    width_m1 = Z3_M1;
      endcase
   end

endmodule

// File: rtl/fps_seq_ctrl.sv
module fps_seq_ctrl
   import fps_pkg::*;
#(
   parameter int unsigned CW        = 4,
   parameter int unsigned Y_CYC     = 3,
   parameter int unsigned ALPHA_CYC = 2,
   parameter int unsigned BETA_CYC  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          expired,
   input  logic [CW-1:0] width_m1,
   output logic          capture,
   output logic          load,
   output logic [CW-1:0] load_val,
   output fps_phase_e    phase_q,
   output fps_phase_e    phase_d
);
   localparam logic [CW-1:0] Y_M1     = CW'(Y_CYC - 1);
   localparam logic [CW-1:0] ALPHA_M1 = CW'(ALPHA_CYC - 1);
   localparam logic [CW-1:0] BETA_M1  = CW'(BETA_CYC - 1);

   always_comb begin
      phase_d  = phase_q;
      load     = 1'b0;
      load_val = '0;
      capture  = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (start) begin
               capture = 1'b1;
               load    = 1'b1;
               phase_d = PH_ARM;
            end
         end
         PH_ARM: begin
            if (expired) begin
               load     = 1'b1;
               load_val = Y_M1;
               phase_d  = PH_SETTLE;
            end
         end
         PH_SETTLE: begin
            if (expired) begin
               load     = 1'b1;
               load_val = width_m1;
               phase_d  = PH_PULSE;
            end
         end
         PH_PULSE: begin
            if (expired) begin
               load     = 1'b1;
               load_val = ALPHA_M1;
               phase_d  = PH_HOLD;
            end
         end
         PH_HOLD: begin
            if (expired) begin
               load     = 1'b1;
               load_val = BETA_M1;
               phase_d  = PH_RELEASE;
            end
         end
         PH_RELEASE: begin
            if (expired) begin
               load    = 1'b1;
               phase_d = PH_FINISH;
            end
         end
         PH_FINISH: phase_d = PH_IDLE;
         default:   phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   AST_BUSY_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE) |=> (phase_q != PH_ARM)); // R6

   AST_PULSE_FROM_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_q == PH_PULSE) |-> ($past(phase_q) == PH_SETTLE)); // R3

endmodule

// File: rtl/fps_strobe_drv.sv
module fps_strobe_drv
   import fps_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  fps_phase_e   phase_q,
   input  fps_phase_e   phase_d,
   output fps_strobes_t strobes
);
   generate
      if (OUT_REG) begin : g_reg
         // decode next phase and register: glitch-free strobes, same timing
         fps_strobes_t s_q;
         always_ff @(posedge clk) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= fps_decode(phase_d);
         end
         assign strobes = s_q;
         logic unused_q;
         assign unused_q = ^phase_q;
      end else begin : g_comb
         assign strobes = fps_decode(phase_q);
         logic unused_d;
         assign unused_d = ^{phase_d, clk, rst_n};
      end
   endgenerate

endmodule

// File: rtl/flash_pulse_seq.sv
module flash_pulse_seq
   import fps_pkg::*;
#(
   parameter int unsigned Y_CYC     = 3,
   parameter int unsigned Z1_CYC    = 4,
   parameter int unsigned Z2_CYC    = 8,
   parameter int unsigned Z3_CYC    = 2,
   parameter int unsigned ALPHA_CYC = 2,
   parameter int unsigned BETA_CYC  = 2,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] width_sel,
   output logic       busy,
   output logic       wdg_en,
   output logic       setup_stb,
   output logic       prog_stb,
   output logic       done
);
   localparam int unsigned MAX_W   = fps_max2(fps_max2(Z1_CYC, Z2_CYC), Z3_CYC);
   localparam int unsigned MAX_D   = fps_max2(fps_max2(Y_CYC, MAX_W), fps_max2(ALPHA_CYC, BETA_CYC));
   localparam int unsigned CW      = (MAX_D < 2) ? 1 : $clog2(MAX_D);
   localparam int unsigned AGE_W   = CW + 1;

   generate
      if (Y_CYC < 1 || Z1_CYC < 1 || Z2_CYC < 1 || Z3_CYC < 1 ||
          ALPHA_CYC < 1 || BETA_CYC < 1) begin : g_bad_delay
         $error("flash_pulse_seq: every delay parameter must be at least one cycle");
      end
   endgenerate

   logic          capture;
   logic          load;
   logic [CW-1:0] load_val;
   logic [CW-1:0] width_m1;
   logic          expired;
   fps_phase_e    phase_q;
   fps_phase_e    phase_d;
   fps_strobes_t  strobes;

   fps_width_sel #(
      .CW(CW), .Z1_CYC(Z1_CYC), .Z2_CYC(Z2_CYC), .Z3_CYC(Z3_CYC)
   ) u_wsel (
      .clk(clk), .rst_n(rst_n), .capture(capture), .sel(width_sel), .width_m1(width_m1)
   );

   fps_phase_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
   );

   fps_seq_ctrl #(
      .CW(CW), .Y_CYC(Y_CYC), .ALPHA_CYC(ALPHA_CYC), .BETA_CYC(BETA_CYC)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .expired(expired), .width_m1(width_m1),
      .capture(capture), .load(load), .load_val(load_val),
      .phase_q(phase_q), .phase_d(phase_d)
   );

   fps_strobe_drv #(.OUT_REG(OUT_REG)) u_drv (
      .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .phase_d(phase_d), .strobes(strobes)
   );

   assign busy      = strobes.busy;
   assign wdg_en    = strobes.wdg;
   assign setup_stb = strobes.setup;
   assign prog_stb  = strobes.prog;
   assign done      = strobes.done;

   // checker-side age of the setup strobe, saturating
   logic [AGE_W-1:0] setup_age;
   always_ff @(posedge clk) begin
      if (!rst_n || !setup_stb)   setup_age <= '0;
      else if (setup_age != '1)   setup_age <= setup_age + 1'b1;
   end

   AST_PROG_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      prog_stb |-> (setup_stb && (32'(setup_age) >= Y_CYC))); // R3

   AST_SETUP_IN_WDG: assert property (@(posedge clk) disable iff (!rst_n)
      setup_stb |-> wdg_en); // R4

   AST_WDG_LEADS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(setup_stb) |-> $past(wdg_en)); // R4

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_DONE_AT_WDG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!wdg_en && $past(wdg_en))); // R7

   AST_WDG_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdg_en) |-> done); // R7

   AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_stb && $past(prog_stb)) |-> $stable(width_m1)); // R8

   AST_BUSY_COVERS_WDG: assert property (@(posedge clk) disable iff (!rst_n)
      (wdg_en || done) |-> busy); // R6

endmodule

// File: tb/tb_flash_pulse_seq.sv
`timescale 1ns/1ps
module tb_flash_pulse_seq;
   localparam int Y  = 3;
   localparam int Z1 = 4;
   localparam int Z2 = 7;
   localparam int Z3 = 2;
   localparam int AL = 2;
   localparam int BE = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] width_sel = 2'b00;
   logic       busy, wdg_en, setup_stb, prog_stb, done;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   flash_pulse_seq #(
      .Y_CYC(Y), .Z1_CYC(Z1), .Z2_CYC(Z2), .Z3_CYC(Z3),
      .ALPHA_CYC(AL), .BETA_CYC(BE), .OUT_REG(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .width_sel(width_sel),
      .busy(busy), .wdg_en(wdg_en), .setup_stb(setup_stb), .prog_stb(prog_stb), .done(done)
   );

   typedef struct {
      int w;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int width_of(input logic [1:0] s);
      // R5: 00 -> Z1, 01 -> Z2, 1x -> Z3
      if (s == 2'b00) return Z1;
      if (s == 2'b01) return Z2;
      return Z3;
   endfunction

   // driver: issue one pulse, optionally disturb it mid-way
   task automatic issue(input logic [1:0] s, input bit disturb, input string tag);
      exp_t e;
      @(negedge clk);
      start = 1'b1;
      width_sel = s;
      e.w = width_of(s);
      e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R6 busy after accept", int'(busy), 1);
      chk(wdg_en == 1'b1 && setup_stb == 1'b0, "R2 wdg leads", int'({wdg_en, setup_stb}), 2);
      if (disturb) begin
         repeat (3) @(negedge clk);
         width_sel = ~s;
         start = 1'b1;   // R6 ignored while busy, R8 select change ignored
         @(negedge clk);
         start = 1'b0;
         repeat (2) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(!busy && !wdg_en && !setup_stb && !prog_stb && !done, "R6 idle after done",
          int'({busy, wdg_en, setup_stb, prog_stb, done}), 0);
   endtask

   // monitor / scoreboard
   logic [2:0] prev_pat = 3'b000;
   logic       prev_done = 1'b0;
   int run = 0;
   int nruns = 0;
   int runs[8];

   always @(negedge clk) begin
      logic [2:0] pat;
      exp_t e;
      int ev[5];
      if (rst_n) begin
         pat = {wdg_en, setup_stb, prog_stb};
         if (pat != prev_pat) begin
            if (prev_pat != 3'b000) begin
               if (nruns < 8) runs[nruns] = run;
               nruns++;
            end
            run = 1;
         end else begin
            run++;
         end
         if (prog_stb && !setup_stb) chk(1'b0, "R3 prog without setup", int'(pat), 3'b111);
         if (setup_stb && !wdg_en)   chk(1'b0, "R4 setup without wdg", int'(pat), 3'b110);
         if (prev_done && done)      chk(1'b0, "R7 done longer than one cycle", 2, 1);
         if (done) begin
            chk(pat == 3'b000 && prev_pat == 3'b100, "R7 done at wdg fall",
                int'({prev_pat, pat}), 6'b100_000);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6 unexpected sequence", 1, 0);
            end else begin
               e = exp_q.pop_front();
               ev[0] = 1; ev[1] = Y; ev[2] = e.w; ev[3] = AL; ev[4] = BE;
               chk(nruns == 5, {"R2 phase count ", e.tag}, nruns, 5);
               for (int i = 0; i < 5; i++) begin
                  if (i < nruns)
                     chk(runs[i] == ev[i], (i == 2) ? {"R5 R8 width ", e.tag}
                                                    : {"R2 phase length ", e.tag},
                         runs[i], ev[i]);
               end
            end
            nruns = 0;
         end
         prev_pat = pat;
         prev_done = done;
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs low in reset
      chk({busy, wdg_en, setup_stb, prog_stb, done} == 5'b0, "R1 reset outputs",
          int'({busy, wdg_en, setup_stb, prog_stb, done}), 0);
      start = 1'b1;   // start during reset must do nothing
      @(negedge clk);
      start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, wdg_en, setup_stb, prog_stb, done} == 5'b0, "R1 after reset release",
          int'({busy, wdg_en, setup_stb, prog_stb, done}), 0);
      issue(2'b00, 1'b0, "short");
      issue(2'b01, 1'b0, "long");
      issue(2'b10, 1'b0, "extra");
      issue(2'b11, 1'b0, "extra alt");
      issue(2'b00, 1'b1, "short disturbed");
      issue(2'b10, 1'b1, "extra disturbed");
      issue(2'b01, 1'b0, "long back-to-back");
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all sequences completed", exp_q.size(), 0);
      summary();
   end

endmodule